// File: doc/BRIEF.md
# Dual-Channel Triggered Capture Buffer

This block records two signed sample streams into a pair of circular buffers that share one write pointer. A decimation stage sets how often a point is written. Its ratio is a power of two, 2^k. In each interval the stage passes on either the last sample or the arithmetic mean of every sample in the interval. A pulse on `arm` starts a capture. From then on the block writes continuously until the selected trigger fires.

After the trigger, the block writes half a buffer plus a programmable delay of further points and then stops. At that point it raises `ready` and reports the address of the oldest stored point. With a delay of zero, the trigger therefore sits in the middle of the trace.

The trigger can be immediate, or a rising or falling crossing on either channel. A crossing counts only when the signal passes through the whole hysteresis band around its threshold in the chosen direction. A 64-bit cycle counter runs from reset, and its value is captured when the trigger fires. Software reads the buffer through a registered read port. It also reads the live inputs, the counter, the trigger time and the status. The default buffer depth is 2^10. For a 2^14 trace per channel, set `ADDR_W` to 14.

Top module: `tcap_top`

## Requirements
- R1: Each channel has a buffer of 2^ADDR_W entries. Both channels are written at the same address. A read returns the stored word on `rd_a`/`rd_b` one clock after `rd_addr` is presented.
- R2: With `decim_log2` = k (0..16), one point is stored every 2^k clocks. With `avg_en` = 0, the stored point is the last sample of its interval, so a ramp that rises by 1 per clock is stored with a step of 2^k.
- R3: With `avg_en` = 1, the stored point is the sum of the 2^k samples in the interval, arithmetically shifted right by k (floor of the mean, correct for negative values). The interval counter restarts on `arm`.
- R4: Rising crossing: the detector is primed once the input is strictly below threshold − hysteresis. It fires when a primed input is strictly above threshold + hysteresis. A constant input never fires, and neither does a rise from inside or above the band without a prior priming.
- R5: Falling crossing: this is the mirror of R4. The detector is primed strictly above threshold + hysteresis and fires strictly below threshold − hysteresis. An input that stays inside the band does not fire.
- R6: `trig_src` selects the trigger: 0 = immediate, 1 = channel A rising, 2 = channel A falling, 3 = channel B rising, 4 = channel B falling. Crossings on the channel or in the direction that is not selected have no effect.
- R7: After the trigger, HALF + `trig_delay` further points are written, where HALF = 2^(ADDR_W−1). With k = 0, the input sample that fires the trigger is stored at ordered position HALF − `trig_delay`, counted from `end_ptr` as position 0.
- R8: `timestamp` is 0 in reset and then rises by 1 every clock. `trig_timestamp` takes the value that `timestamp` shows in the clock after the firing input sample is applied, and it changes at no other time.
- R9: `ready` is 0 in reset and in the clock after `arm`. It goes to 1 when the post-trigger writes finish and holds until the next `arm`. At that moment `end_ptr` is set to the address of the oldest stored point.
- R10: `live_a`/`live_b` show the input pins delayed by one clock.
- R11: After reset, `ready`, `trig_timestamp` and `end_ptr` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm | input | 1 | One-clock pulse that starts a capture |
| trig_src | input | 3 | Trigger selection (R6) |
| decim_log2 | input | 5 | Decimation exponent k |
| avg_en | input | 1 | Store interval mean instead of last sample |
| trig_delay | input | ADDR_W-1 | Extra post-trigger points |
| thr_a | input | DATA_W | Channel A threshold, signed |
| hyst_a | input | DATA_W | Channel A hysteresis, unsigned |
| thr_b | input | DATA_W | Channel B threshold, signed |
| hyst_b | input | DATA_W | Channel B hysteresis, unsigned |
| in_a | input | DATA_W | Channel A sample, signed |
| in_b | input | DATA_W | Channel B sample, signed |
| rd_addr | input | ADDR_W | Buffer read address |
| rd_a | output | DATA_W | Channel A stored point |
| rd_b | output | DATA_W | Channel B stored point |
| live_a | output | DATA_W | Registered channel A input |
| live_b | output | DATA_W | Registered channel B input |
| ready | output | 1 | Capture complete |
| end_ptr | output | ADDR_W | Address of oldest stored point |
| timestamp | output | TS_W | Free-running cycle count |
| trig_timestamp | output | TS_W | Cycle count latched at trigger |

## Verification
The trigger acceptance and a decimated write can land in the same clock. The open question is whether that point belongs to the pre-trigger or the post-trigger part of the trace. With k = 0 a point is written every clock, so every trigger collides with a write. The bench drives a distinct value just before the crossing and the crossing value itself, and it does this with delays of 0 and 100. It then checks that the crossing value sits exactly at position HALF − delay and the value before it at the position just ahead. A one-point error in either direction shows up as a mismatch.

// File: rtl/tcap_pkg.sv
package tcap_pkg;
  typedef enum logic [2:0] {
    SRC_NOW    = 3'd0,
    SRC_A_RISE = 3'd1,
    SRC_A_FALL = 3'd2,
    SRC_B_RISE = 3'd3,
    SRC_B_FALL = 3'd4
  } trig_src_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_POST  = 2'd2
  } cap_state_e;
endpackage

// File: rtl/tcap_decim.sv
// Decimator: emits one point per 2^k samples, either the last sample
// or the floored mean obtained by an arithmetic shift of the sum.
module tcap_decim #(
  parameter int DATA_W = 14,
  parameter int KMAX   = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr,
  input  logic [$clog2(KMAX+1)-1:0] k,
  input  logic                      avg_en,
  input  logic signed [DATA_W-1:0]  din,
  output logic                      vld,
  output logic signed [DATA_W-1:0]  dout
);
  localparam int CNT_W = KMAX;
  localparam int ACC_W = DATA_W + KMAX;

  logic [CNT_W-1:0]        cnt_q, cnt_d;
  logic signed [ACC_W-1:0] acc_q, acc_d, sum, shifted;
  logic [CNT_W:0]          span;
  logic                    last;
  logic                    vld_d;
  logic signed [DATA_W-1:0] dout_d;

  always_comb begin
    span    = ((CNT_W+1)'(1) << k) - (CNT_W+1)'(1);
    last    = (cnt_q == span[CNT_W-1:0]);
    sum     = acc_q + ACC_W'(din);
    shifted = sum >>> k;
    cnt_d   = cnt_q;
    acc_d   = acc_q;
    vld_d   = 1'b0;
    dout_d  = dout;
    if (clr) begin
      cnt_d = '0;
      acc_d = '0;
    end else if (last) begin
      cnt_d  = '0;
      acc_d  = '0;
      vld_d  = 1'b1;
      dout_d = avg_en ? shifted[DATA_W-1:0] : din;
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
      acc_d = sum;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      acc_q <= '0;
      vld   <= 1'b0;
      dout  <= '0;
    end else begin
      cnt_q <= cnt_d;
      acc_q <= acc_d;
      vld   <= vld_d;
      dout  <= dout_d;
    end
  end
endmodule

// File: rtl/tcap_edge.sv
// Hysteresis crossing detector for both directions on one channel.
module tcap_edge #(
  parameter int DATA_W = 14
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic signed [DATA_W-1:0] x,
  input  logic signed [DATA_W-1:0] thr,
  input  logic [DATA_W-1:0]        hyst,
  output logic                     rise,
  output logic                     fall
);
  localparam int CW = DATA_W + 2;

  logic signed [CW-1:0] xe, lo, hi;
  logic below, above;
  logic up_q, up_d, dn_q, dn_d;

  always_comb begin
    xe    = CW'(x);
    lo    = CW'(thr) - $signed({2'b00, hyst});
    hi    = CW'(thr) + $signed({2'b00, hyst});
    below = (xe < lo);
    above = (xe > hi);
    rise  = up_q && above;
    fall  = dn_q && below;
    up_d  = up_q;
    dn_d  = dn_q;
    if (clr) begin
      up_d = 1'b0;
      dn_d = 1'b0;
    end else begin
      if (below)     up_d = 1'b1;
      else if (rise) up_d = 1'b0;
      if (above)     dn_d = 1'b1;
      else if (fall) dn_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else begin
      up_q <= up_d;
      dn_q <= dn_d;
    end
  end
endmodule

// File: rtl/tcap_mem.sv
// Simple dual-port store with registered read.
module tcap_mem #(
  parameter int W      = 28,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [W-1:0]      wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [W-1:0]      rdata
);
  localparam int DEPTH = 2 ** ADDR_W;

  logic [W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    rdata <= store[raddr];
  end
endmodule

// File: rtl/tcap_ctrl.sv
// Capture sequencer, write pointer, cycle counter and trigger time.
module tcap_ctrl
  import tcap_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int TS_W   = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic              hit,
  input  logic              vld,
  input  logic [ADDR_W-2:0] delay,
  output cap_state_e        st,
  output logic              we,
  output logic [ADDR_W-1:0] waddr,
  output logic              ready,
  output logic [ADDR_W-1:0] end_ptr,
  output logic [TS_W-1:0]   ts,
  output logic [TS_W-1:0]   trig_ts
);
  localparam int HALF  = 2 ** (ADDR_W - 1);
  localparam int REM_W = ADDR_W;

  cap_state_e        st_d;
  logic [ADDR_W-1:0] wptr_d, endp_d;
  logic [REM_W-1:0]  rem_q, rem_d, rem_load;
  logic              rdy_d;
  logic [TS_W-1:0]   ts_d, tts_d;

  assign we    = vld && (st != ST_IDLE);
  assign waddr = end_ptr_w;

  logic [ADDR_W-1:0] end_ptr_w;

  always_comb begin
    rem_load = REM_W'(HALF) + REM_W'(delay);
    st_d     = st;
    wptr_d   = end_ptr_w;
    rem_d    = rem_q;
    rdy_d    = ready;
    endp_d   = end_ptr;
    tts_d    = trig_ts;
    ts_d     = ts + TS_W'(1);
    if (we) wptr_d = end_ptr_w + ADDR_W'(1);
    if (arm) begin
      st_d  = ST_ARMED;
      rdy_d = 1'b0;
    end else begin
      case (st)
        ST_ARMED: if (hit) begin
          st_d  = ST_POST;
          rem_d = rem_load;
          tts_d = ts;
        end
        ST_POST: if (we) begin
          if (rem_q == REM_W'(1)) begin
            st_d   = ST_IDLE;
            rdy_d  = 1'b1;
            endp_d = end_ptr_w + ADDR_W'(1);
          end else begin
            rem_d = rem_q - REM_W'(1);
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      end_ptr_w <= '0;
      rem_q     <= '0;
      ready     <= 1'b0;
      end_ptr   <= '0;
      ts        <= '0;
      trig_ts   <= '0;
    end else begin
      st        <= st_d;
      end_ptr_w <= wptr_d;
      rem_q     <= rem_d;
      ready     <= rdy_d;
      end_ptr   <= endp_d;
      ts        <= ts_d;
      trig_ts   <= tts_d;
    end
  end
endmodule

// File: rtl/tcap_top.sv
module tcap_top
  import tcap_pkg::*;
#(
  parameter int DATA_W = 14,
  parameter int ADDR_W = 10,
  parameter int KMAX   = 16,
  parameter int TS_W   = 64
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      arm,
  input  logic [2:0]                trig_src,
  input  logic [$clog2(KMAX+1)-1:0] decim_log2,
  input  logic                      avg_en,
  input  logic [ADDR_W-2:0]         trig_delay,
  input  logic signed [DATA_W-1:0]  thr_a,
  input  logic [DATA_W-1:0]         hyst_a,
  input  logic signed [DATA_W-1:0]  thr_b,
  input  logic [DATA_W-1:0]         hyst_b,
  input  logic signed [DATA_W-1:0]  in_a,
  input  logic signed [DATA_W-1:0]  in_b,
  input  logic [ADDR_W-1:0]         rd_addr,
  output logic signed [DATA_W-1:0]  rd_a,
  output logic signed [DATA_W-1:0]  rd_b,
  output logic signed [DATA_W-1:0]  live_a,
  output logic signed [DATA_W-1:0]  live_b,
  output logic                      ready,
  output logic [ADDR_W-1:0]         end_ptr,
  output logic [TS_W-1:0]           timestamp,
  output logic [TS_W-1:0]           trig_timestamp
);
  localparam int NCH = 2;
  localparam int W   = NCH * DATA_W;

  logic signed [DATA_W-1:0] pin   [NCH];
  logic signed [DATA_W-1:0] thr   [NCH];
  logic [DATA_W-1:0]        hyst  [NCH];
  logic signed [DATA_W-1:0] smp_q [NCH];
  logic signed [DATA_W-1:0] dec   [NCH];
  logic [NCH-1:0]           dvld, rise, fall;
  logic                     hit, we;
  logic [ADDR_W-1:0]        waddr;
  logic [W-1:0]             wdata, rdata;
  cap_state_e               st;

  assign pin[0]  = in_a;
  assign pin[1]  = in_b;
  assign thr[0]  = thr_a;
  assign thr[1]  = thr_b;
  assign hyst[0] = hyst_a;
  assign hyst[1] = hyst_b;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) smp_q[c] <= '0;
      else        smp_q[c] <= pin[c];
    end

    tcap_decim #(.DATA_W(DATA_W), .KMAX(KMAX)) u_decim (
      .clk(clk), .rst_n(rst_n), .clr(arm), .k(decim_log2), .avg_en(avg_en),
      .din(smp_q[c]), .vld(dvld[c]), .dout(dec[c])
    );

    tcap_edge #(.DATA_W(DATA_W)) u_edge (
      .clk(clk), .rst_n(rst_n), .clr(arm), .x(smp_q[c]), .thr(thr[c]),
      .hyst(hyst[c]), .rise(rise[c]), .fall(fall[c])
    );

    assign wdata[c*DATA_W +: DATA_W] = dec[c];
  end

  always_comb begin
    case (trig_src_e'(trig_src))
      SRC_NOW:    hit = 1'b1;
      SRC_A_RISE: hit = rise[0];
      SRC_A_FALL: hit = fall[0];
      SRC_B_RISE: hit = rise[1];
      SRC_B_FALL: hit = fall[1];
      default:    hit = 1'b0;
    endcase
  end

  tcap_ctrl #(.ADDR_W(ADDR_W), .TS_W(TS_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .arm(arm), .hit(hit), .vld(dvld[0]),
    .delay(trig_delay), .st(st), .we(we), .waddr(waddr), .ready(ready),
    .end_ptr(end_ptr), .ts(timestamp), .trig_ts(trig_timestamp)
  );

  tcap_mem #(.W(W), .ADDR_W(ADDR_W)) u_mem (
    .clk(clk), .we(we), .waddr(waddr), .wdata(wdata),
    .raddr(rd_addr), .rdata(rdata)
  );

  assign rd_a   = rdata[DATA_W-1:0];
  assign rd_b   = rdata[W-1:DATA_W];
  assign live_a = smp_q[0];
  assign live_b = smp_q[1];
endmodule

// File: rtl/tcap_chk.sv
module tcap_chk
  import tcap_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int TS_W   = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              arm,
  input logic              ready,
  input logic [TS_W-1:0]   timestamp,
  input logic [TS_W-1:0]   trig_timestamp,
  input logic [ADDR_W-1:0] end_ptr,
  input cap_state_e        st
);
  assert_ts_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> timestamp == $past(timestamp) + TS_W'(1));

  assert_tts_when_armed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$stable(trig_timestamp)) |-> $past(st) == ST_ARMED);

  assert_arm_drops_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> !ready);

  assert_ready_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !arm) |=> ready);

  assert_endptr_at_finish_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$stable(end_ptr)) |-> ($past(st) == ST_POST && $rose(ready)));
endmodule

bind tcap_top tcap_chk #(.ADDR_W(ADDR_W), .TS_W(TS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .arm(arm), .ready(ready), .timestamp(timestamp),
  .trig_timestamp(trig_timestamp), .end_ptr(end_ptr), .st(st)
);

// File: tb/tb_tcap_top.sv
module tb_tcap_top;
  localparam int CLK_PERIOD = 8;
  localparam int ADDR_W     = 10;
  localparam int DEPTH      = 2 ** ADDR_W;
  localparam int HALF       = DEPTH / 2;
  localparam int WD_CYCLES  = 150000;

  logic clk = 1'b0;
  logic rst_n, arm, avg_en;
  logic [2:0] trig_src;
  logic [4:0] decim_log2;
  logic [ADDR_W-2:0] trig_delay;
  logic signed [13:0] thr_a, thr_b, in_a, in_b, rd_a, rd_b, live_a, live_b;
  logic [13:0] hyst_a, hyst_b;
  logic [ADDR_W-1:0] rd_addr, end_ptr;
  logic ready;
  logic [63:0] timestamp, trig_timestamp;

  int checks = 0;
  int failures = 0;
  int mode = 0;
  logic signed [13:0] rc = '0;
  bit alt = 1'b0;

  tcap_top dut (
    .clk(clk), .rst_n(rst_n), .arm(arm), .trig_src(trig_src), .decim_log2(decim_log2),
    .avg_en(avg_en), .trig_delay(trig_delay), .thr_a(thr_a), .hyst_a(hyst_a),
    .thr_b(thr_b), .hyst_b(hyst_b), .in_a(in_a), .in_b(in_b), .rd_addr(rd_addr),
    .rd_a(rd_a), .rd_b(rd_b), .live_a(live_a), .live_b(live_b), .ready(ready),
    .end_ptr(end_ptr), .timestamp(timestamp), .trig_timestamp(trig_timestamp)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    forever begin
      @(negedge clk);
      if (mode == 1) begin
        in_a = rc; in_b = -rc; rc = rc + 14'sd1;
      end else if (mode == 2) begin
        alt = !alt;
        in_a = alt ? 14'sd100 : 14'sd200;
        in_b = alt ? -14'sd101 : -14'sd200;
      end
    end
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired actual=%0d expected=0", WD_CYCLES);
    summary();
    $finish;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic arm_pulse();
    @(negedge clk) arm = 1'b1;
    @(negedge clk) arm = 1'b0;
    chk(ready == 1'b0, "R9", "ready after arm", longint'(ready), 0);
  endtask

  task automatic wait_ready(input int lim);
    for (int n = 0; n < lim && !ready; n++) @(negedge clk);
    chk(ready == 1'b1, "R9", "ready after capture", longint'(ready), 1);
  endtask

  task automatic read_pos(input int p, output logic signed [13:0] a, output logic signed [13:0] b);
    @(negedge clk) rd_addr = end_ptr + ADDR_W'(p);
    @(negedge clk);
    a = rd_a; b = rd_b;
  endtask

  task automatic setup(input logic [2:0] src, input logic [4:0] k, input logic av,
                       input int dly);
    @(negedge clk);
    trig_src = src; decim_log2 = k; avg_en = av; trig_delay = (ADDR_W-1)'(dly);
  endtask

  // R11, R8: reset values and counter progression
  task automatic t_reset();
    longint t0;
    chk(ready == 1'b0, "R11", "ready at reset", longint'(ready), 0);
    chk(trig_timestamp == 0, "R11", "trig_timestamp at reset", longint'(trig_timestamp), 0);
    chk(end_ptr == 0, "R11", "end_ptr at reset", longint'(end_ptr), 0);
    t0 = longint'(timestamp);
    hold(10);
    chk(longint'(timestamp) - t0 == 10, "R8", "timestamp advance", longint'(timestamp) - t0, 10);
  endtask

  // R1, R2, R6, R7, R9, R10: immediate trigger, full-rate ramp
  task automatic t_immediate();
    logic signed [13:0] a, b, pa;
    int e_pair = 0, e_step = 0;
    setup(3'd0, 5'd0, 1'b0, 0);
    mode = 1;
    arm_pulse();
    wait_ready(3000);
    for (int p = HALF; p < DEPTH; p++) begin
      read_pos(p, a, b);
      if (14'(a + b) != 14'd0) e_pair++;
      if (p > HALF && 14'(a - pa) != 14'd1) e_step++;
      pa = a;
    end
    chk(e_pair == 0, "R1", "channel pairing errors", e_pair, 0);
    chk(e_step == 0, "R2", "k=0 ramp step errors", e_step, 0);
    chk(ready == 1'b1, "R9", "ready held while idle", longint'(ready), 1);
    @(negedge clk) mode = 0;
    @(negedge clk) begin in_a = 14'sd123; in_b = -14'sd77; end
    @(negedge clk);
    chk(live_a == 14'sd123, "R10", "live_a", longint'(live_a), 123);
    chk(live_b == -14'sd77, "R10", "live_b", longint'(live_b), -77);
  endtask

  // R2: decimation by 4, no averaging
  task automatic t_decim();
    logic signed [13:0] a, b, pa;
    int e_step = 0;
    setup(3'd0, 5'd2, 1'b0, 0);
    mode = 1;
    arm_pulse();
    wait_ready(5000);
    for (int p = HALF; p < DEPTH; p++) begin
      read_pos(p, a, b);
      if (p > HALF && 14'(a - pa) != 14'd4) e_step++;
      pa = a;
    end
    chk(e_step == 0, "R2", "k=2 ramp step errors", e_step, 0);
  endtask

  // R3, R2: alternating input, averaging on and off
  task automatic t_avg();
    logic signed [13:0] a, b, a0;
    int e_a = 0, e_b = 0, e_c = 0;
    setup(3'd0, 5'd1, 1'b1, 0);
    mode = 2;
    arm_pulse();
    wait_ready(3000);
    for (int p = HALF; p < DEPTH; p++) begin
      read_pos(p, a, b);
      if (a != 14'sd150) e_a++;
      if (b != -14'sd151) e_b++;
    end
    chk(e_a == 0, "R3", "mean of 100/200 errors", e_a, 0);
    chk(e_b == 0, "R3", "floored mean of -101/-200 errors", e_b, 0);
    setup(3'd0, 5'd1, 1'b0, 0);
    arm_pulse();
    wait_ready(3000);
    read_pos(HALF, a0, b);
    for (int p = HALF + 1; p < DEPTH; p++) begin
      read_pos(p, a, b);
      if (a != a0) e_c++;
    end
    chk(e_c == 0 && (a0 == 14'sd100 || a0 == 14'sd200), "R2",
        "no-average points equal one phase", e_c, 0);
  endtask

  // R4, R6, R7, R8: channel A rising crossing, delay 0
  task automatic t_rise();
    logic signed [13:0] a, b;
    longint pv, t;
    @(negedge clk) begin
      mode = 0; in_a = 14'sd0; in_b = 14'sd0;
      thr_a = 14'sd0; hyst_a = 14'd10;
    end
    setup(3'd1, 5'd0, 1'b0, 0);
    pv = longint'(trig_timestamp);
    arm_pulse();
    hold(40);
    chk(longint'(trig_timestamp) == pv, "R4", "constant input fired", longint'(trig_timestamp), pv);
    in_a = 14'sd20; hold(5);
    chk(longint'(trig_timestamp) == pv, "R4", "unprimed rise fired", longint'(trig_timestamp), pv);
    in_a = -14'sd20; hold(5);
    in_a = 14'sd5; hold(5);
    chk(longint'(trig_timestamp) == pv, "R6", "falling move fired rising source", longint'(trig_timestamp), pv);
    t = longint'(timestamp);
    in_a = 14'sd20;
    wait_ready(3000);
    chk(longint'(trig_timestamp) == t + 1, "R8", "trigger time", longint'(trig_timestamp), t + 1);
    read_pos(HALF, a, b);
    chk(a == 14'sd20, "R7", "crossing sample position", longint'(a), 20);
    read_pos(HALF - 1, a, b);
    chk(a == 14'sd5, "R7", "sample before crossing", longint'(a), 5);
  endtask

  // R5, R6, R7, R8: channel B falling crossing with delay 100
  task automatic t_fall();
    logic signed [13:0] a, b;
    longint pv, t;
    @(negedge clk) begin
      in_a = 14'sd0; in_b = 14'sd0;
      thr_b = 14'sd50; hyst_b = 14'd5;
    end
    setup(3'd4, 5'd0, 1'b0, 100);
    pv = longint'(trig_timestamp);
    arm_pulse();
    in_b = 14'sd60; hold(5);
    in_a = -14'sd20; hold(5);
    in_a = 14'sd20; hold(5);
    chk(longint'(trig_timestamp) == pv, "R6", "channel A crossing fired B source", longint'(trig_timestamp), pv);
    in_b = 14'sd50; hold(5);
    chk(longint'(trig_timestamp) == pv, "R5", "in-band input fired", longint'(trig_timestamp), pv);
    t = longint'(timestamp);
    in_b = 14'sd40;
    wait_ready(3000);
    chk(longint'(trig_timestamp) == t + 1, "R8", "falling trigger time", longint'(trig_timestamp), t + 1);
    read_pos(HALF - 100, a, b);
    chk(b == 14'sd40, "R7", "delayed crossing position", longint'(b), 40);
    read_pos(HALF - 101, a, b);
    chk(b == 14'sd50, "R5", "sample before falling crossing", longint'(b), 50);
  endtask

  initial begin
    rst_n = 1'b0; arm = 1'b0; trig_src = 3'd0; decim_log2 = 5'd0; avg_en = 1'b0;
    trig_delay = '0; thr_a = '0; thr_b = '0; hyst_a = '0; hyst_b = '0;
    in_a = '0; in_b = '0; rd_addr = '0;
    hold(3);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_immediate();
    t_decim();
    t_avg();
    t_rise();
    t_fall();
    summary();
    $finish;
  end
endmodule